// File: doc/BRIEF.md
# Eight-Pin GPIO Port Register Block

This block is the register front end of an eight-pin general-purpose I/O port. A simple synchronous register bus (address, write data, write strobe, read strobe, read data) reaches a direction register, a set-only alias of that direction register, an output register, a synchronised input register, a per-pin configuration register for each pin, and a broadcast mask for the configuration registers. The pads are modelled as three vectors. The block drives an output-enable vector and a driven-value vector, and it receives an input-value vector. The configuration bytes of all pins also leave the block on a flat bus, so that pad logic outside the block can use them.

Software can mark pins as outputs through the set-only alias without a read-modify-write. Loading the broadcast mask makes the next configuration write program every masked pin together with the addressed pin, and the mask then clears itself. The bus has no data stream that needs back-pressure: each access takes one cycle, and the block cannot stall a request, so the bus stays plain strobes with no valid/ready pair.

Top module: `gpio_port`

Register offsets: direction 0x00, direction-set 0x01, output 0x02, input 0x03, broadcast mask 0x04, pin n configuration 0x08+n. Any other offset is unmapped.

## Requirements
- R1: After reset, the direction, output, mask and all eight configuration registers are zero. Read data is zero, and the output-enable and driven-value pad vectors are zero.
- R2: A write to offset 0x00 loads the whole direction register. Each pad output enable equals its direction bit (1 = output, 0 = input). Reading 0x00 returns that register.
- R3: A write to offset 0x01 sets every direction bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R4: A read of offset 0x01 returns the current direction register.
- R5: A write to offset 0x02 loads the output register. Each pad driven value equals its output bit, whatever the direction. Reading 0x02 returns the register.
- R6: Offset 0x03 returns the pad inputs through a two-flop synchronizer. A read captured on the first or second clock edge after an input change still shows the old value, and one captured on the third edge shows the new value. Writes to 0x03 change no register.
- R7: With the mask zero, a write to offset 0x08+n changes only pin n's configuration register. This is visible on read-back and on the pin configuration bus, where pin n occupies bits [8n+7:8n].
- R8: With mask bit n set, a write to any configuration offset also loads pin n's register. The addressed pin's register is loaded whether or not its own mask bit is set.
- R9: Offset 0x04 loads and reads back the mask. Any configuration write clears the mask at the same edge that updates the configuration registers.
- R10: Read data is registered. It shows the selected register one cycle after the read strobe, it holds its value while the read strobe is low, and it returns zero for an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven value |
| pad_in | input | 8 | Per-pin sensed value, asynchronous |
| pin_cfg | output | 64 | Configuration bytes of all pins, pin n at [8n+7:8n] |

## Verification
A write is sampled on one rising edge, and its effect on the pads, on the pin configuration bus and on the mask is due by the next falling edge. The bench drives each strobe on a falling edge and checks those outputs one falling edge later. Read data is due one edge after the strobe, so each read check samples at the falling edge that follows the capturing edge. A pad input change needs three capturing edges before it is readable, so the input test holds the read strobe high and checks the read data at three consecutive falling edges: old, old, then new.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned OFS_DIR    = 0;
  localparam int unsigned OFS_DIRSET = 1;
  localparam int unsigned OFS_OUT    = 2;
  localparam int unsigned OFS_IN     = 3;
  localparam int unsigned OFS_MASK   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DIRSET,
    SEL_OUT,
    SEL_IN,
    SEL_MASK,
    SEL_CFG
  } reg_sel_e;

endpackage

// File: rtl/gpio_port_decode.sv
module gpio_port_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned PINS     = 8,
  parameter int unsigned CFG_BASE = 8,
  localparam int unsigned IDX_W   = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic [IDX_W-1:0]  pin_idx_o
);

  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(CFG_BASE + PINS - 1);

  logic [ADDR_W-1:0] cfg_off;

  assign cfg_off   = addr_i - CFG_LO;
  assign pin_idx_o = cfg_off[IDX_W-1:0];

  always_comb begin
    if (addr_i >= CFG_LO && addr_i <= CFG_HI) begin
      sel_o = SEL_CFG;
    end else begin
      unique case (addr_i)
        ADDR_W'(OFS_DIR):    sel_o = SEL_DIR;
        ADDR_W'(OFS_DIRSET): sel_o = SEL_DIRSET;
        ADDR_W'(OFS_OUT):    sel_o = SEL_OUT;
        ADDR_W'(OFS_IN):     sel_o = SEL_IN;
        ADDR_W'(OFS_MASK):   sel_o = SEL_MASK;
        default:             sel_o = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            set_i,
  input  logic [PINS-1:0] data_i,
  output logic [PINS-1:0] dir_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o <= '0;
    end else if (load_i) begin
      dir_o <= data_i;
    end else if (set_i) begin
      dir_o <= dir_o | data_i;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PINS   = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] raw_i,
  output logic [PINS-1:0] sync_o
);

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[p]};
      end
    end

    assign sync_o[p] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank #(
  parameter int unsigned PINS  = 8,
  parameter int unsigned CFG_W = 8,
  localparam int unsigned IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mask_wr_i,
  input  logic [PINS-1:0]       mask_data_i,
  input  logic                  cfg_wr_i,
  input  logic [IDX_W-1:0]      pin_idx_i,
  input  logic [CFG_W-1:0]      cfg_data_i,
  output logic [PINS-1:0]       mask_o,
  output logic [PINS*CFG_W-1:0] cfg_flat_o
);

  // A configuration write consumes the mask, so the mask lives only until the next one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
    end else if (cfg_wr_i) begin
      mask_o <= '0;
    end else if (mask_wr_i) begin
      mask_o <= mask_data_i;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_cfg
    logic             hit;
    logic [CFG_W-1:0] cfg_q;

    assign hit = cfg_wr_i && (mask_o[p] || (pin_idx_i == IDX_W'(p)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q <= '0;
      end else if (hit) begin
        cfg_q <= cfg_data_i;
      end
    end

    assign cfg_flat_o[p*CFG_W +: CFG_W] = cfg_q;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned PINS     = 8,
  parameter int unsigned CFG_W    = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CFG_BASE = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [PINS-1:0]       pad_oe,
  output logic [PINS-1:0]       pad_out,
  input  logic [PINS-1:0]       pad_in,
  output logic [PINS*CFG_W-1:0] pin_cfg
);

  localparam int unsigned IDX_W = (PINS > 1) ? $clog2(PINS) : 1;

  reg_sel_e          sel;
  logic [IDX_W-1:0]  pin_idx;
  logic [PINS-1:0]   dir_q;
  logic [PINS-1:0]   out_q;
  logic [PINS-1:0]   in_sync;
  logic [PINS-1:0]   cfg_mask;
  logic [DATA_W-1:0] rd_mux;

  gpio_port_decode #(
    .ADDR_W   (ADDR_W),
    .PINS     (PINS),
    .CFG_BASE (CFG_BASE)
  ) u_decode (
    .addr_i    (bus_addr),
    .sel_o     (sel),
    .pin_idx_o (pin_idx)
  );

  gpio_dir_reg #(
    .PINS (PINS)
  ) u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (bus_wr && sel == SEL_DIR),
    .set_i  (bus_wr && sel == SEL_DIRSET),
    .data_i (bus_wdata[PINS-1:0]),
    .dir_o  (dir_q)
  );

  gpio_in_sync #(
    .PINS   (PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pad_in),
    .sync_o (in_sync)
  );

  gpio_cfg_bank #(
    .PINS  (PINS),
    .CFG_W (CFG_W)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr_i   (bus_wr && sel == SEL_MASK),
    .mask_data_i (bus_wdata[PINS-1:0]),
    .cfg_wr_i    (bus_wr && sel == SEL_CFG),
    .pin_idx_i   (pin_idx),
    .cfg_data_i  (bus_wdata[CFG_W-1:0]),
    .mask_o      (cfg_mask),
    .cfg_flat_o  (pin_cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (bus_wr && sel == SEL_OUT) begin
      out_q <= bus_wdata[PINS-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DIR,
      SEL_DIRSET: rd_mux = DATA_W'(dir_q);
      SEL_OUT:    rd_mux = DATA_W'(out_q);
      SEL_IN:     rd_mux = DATA_W'(in_sync);
      SEL_MASK:   rd_mux = DATA_W'(cfg_mask);
      SEL_CFG:    rd_mux = DATA_W'(pin_cfg[pin_idx*CFG_W +: CFG_W]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  assign pad_oe  = dir_q;
  assign pad_out = out_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned PINS     = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CFG_BASE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [PINS-1:0]   pad_oe,
  input logic [PINS-1:0]   pad_out,
  input logic [PINS-1:0]   cfg_mask
);

  logic at_cfg;
  logic at_mapped;

  assign at_cfg    = (int'(bus_addr) >= CFG_BASE) && (int'(bus_addr) < CFG_BASE + PINS);
  assign at_mapped = at_cfg || (int'(bus_addr) <= 4);

  AST_OE_LOADS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=> (pad_oe == $past(bus_wdata[PINS-1:0]))); // R2

  AST_OE_ONLY_BY_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == ADDR_W'(0) || bus_addr == ADDR_W'(1))) |=> $stable(pad_oe)); // R2

  AST_DIRSET_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> (pad_oe == ($past(pad_oe) | $past(bus_wdata[PINS-1:0])))); // R3

  AST_OUT_DRIVES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(2)) |=> (pad_out == $past(bus_wdata[PINS-1:0]))); // R5

  AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && at_cfg) |=> (cfg_mask == '0)); // R9

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !at_mapped) |=> (bus_rdata == '0)); // R10

endmodule

bind gpio_port gpio_port_chk #(
  .ADDR_W   (ADDR_W),
  .PINS     (PINS),
  .DATA_W   (DATA_W),
  .CFG_BASE (CFG_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .cfg_mask  (cfg_mask)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic [7:0]  pad_oe;
  logic [7:0]  pad_out;
  logic [7:0]  pad_in = '0;
  logic [63:0] pin_cfg;

  int tests  = 0;
  int failed = 0;
  logic [7:0] exp_cfg [8];

  always #2 clk = ~clk;

  gpio_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_rdata (rdata),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_in    (pad_in),
    .pin_cfg   (pin_cfg)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [63:0] cfg_vec();
    logic [63:0] v;
    for (int p = 0; p < 8; p++) v[p*8 +: 8] = exp_cfg[p];
    return v;
  endfunction

  task automatic check_all_cfg(input string req);
    logic [7:0] d;
    for (int p = 0; p < 8; p++) begin
      rd_reg(5'(8 + p), d);
      chk(req, d, exp_cfg[p]);
    end
    chk(req, pin_cfg, cfg_vec());
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    rd_reg(5'h00, d); chk("R1 dir", d, 8'h00);
    rd_reg(5'h02, d); chk("R1 out", d, 8'h00);
    rd_reg(5'h04, d); chk("R1 mask", d, 8'h00);
    for (int p = 0; p < 8; p++) exp_cfg[p] = 8'h00;
    check_all_cfg("R1 cfg");
  endtask

  task automatic t_dir();
    logic [7:0] d;
    wr_reg(5'h00, 8'hA5);
    chk("R2 oe after load", pad_oe, 8'hA5);
    rd_reg(5'h00, d); chk("R2 dir readback", d, 8'hA5);
    wr_reg(5'h00, 8'h0F);
    chk("R2 oe clears bits", pad_oe, 8'h0F);
  endtask

  task automatic t_dirset();
    logic [7:0] d;
    wr_reg(5'h00, 8'h81);
    wr_reg(5'h01, 8'h42);
    chk("R3 set keeps zeros", pad_oe, 8'hC3);
    wr_reg(5'h01, 8'h00);
    chk("R3 zero write no effect", pad_oe, 8'hC3);
    rd_reg(5'h01, d); chk("R4 dirset reads dir", d, 8'hC3);
  endtask

  task automatic t_out();
    logic [7:0] d;
    wr_reg(5'h00, 8'h00);
    wr_reg(5'h02, 8'h5A);
    chk("R5 pad_out with inputs", pad_out, 8'h5A);
    rd_reg(5'h02, d); chk("R5 out readback", d, 8'h5A);
  endtask

  task automatic t_in_sync();
    @(negedge clk);
    pad_in = 8'h3C; addr = 5'h03; rd = 1'b1;
    @(negedge clk); chk("R6 edge1 old", rdata, 8'h00);
    @(negedge clk); chk("R6 edge2 old", rdata, 8'h00);
    @(negedge clk); chk("R6 edge3 new", rdata, 8'h3C);
    rd = 1'b0;
  endtask

  task automatic t_in_readonly();
    logic [7:0] d;
    wr_reg(5'h03, 8'hFF);
    rd_reg(5'h03, d); chk("R6 write to input ignored", d, 8'h3C);
    chk("R6 oe untouched", pad_oe, 8'h00);
    chk("R6 out untouched", pad_out, 8'h5A);
  endtask

  task automatic t_cfg_single();
    wr_reg(5'h0B, 8'h77); exp_cfg[3] = 8'h77;
    check_all_cfg("R7 single pin");
  endtask

  task automatic t_cfg_broadcast();
    logic [7:0] d;
    wr_reg(5'h04, 8'h05);
    rd_reg(5'h04, d); chk("R9 mask readback", d, 8'h05);
    wr_reg(5'h0E, 8'h3C);
    exp_cfg[0] = 8'h3C; exp_cfg[2] = 8'h3C; exp_cfg[6] = 8'h3C;
    check_all_cfg("R8 broadcast plus addressed");
    rd_reg(5'h04, d); chk("R9 mask cleared", d, 8'h00);
    wr_reg(5'h09, 8'h11); exp_cfg[1] = 8'h11;
    check_all_cfg("R9 next write single");
    wr_reg(5'h04, 8'h80);
    wr_reg(5'h0F, 8'hE1); exp_cfg[7] = 8'hE1;
    check_all_cfg("R8 addressed pin in mask");
  endtask

  task automatic t_read_path();
    logic [7:0] d;
    rd_reg(5'h00, d);
    rd_reg(5'h05, d); chk("R10 unmapped 0x05", d, 8'h00);
    rd_reg(5'h1F, d); chk("R10 unmapped 0x1F", d, 8'h00);
    rd_reg(5'h02, d); chk("R10 read out", d, 8'h5A);
    wr_reg(5'h02, 8'hC7);
    repeat (2) @(negedge clk);
    chk("R10 rdata holds without read", rdata, 8'h5A);
    chk("R5 pad_out updated", pad_out, 8'hC7);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_dir();
    t_dirset();
    t_out();
    t_in_sync();
    t_in_readonly();
    t_cfg_single();
    t_cfg_broadcast();
    t_read_path();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule